// File: doc/BRIEF.md
# DMA Channel Status, Error Code and Interrupt Vector Logic

This block holds the per-channel status flags and the error code of a DMA controller channel. It also drives the channel's interrupt request and vector. The transfer engine reports what happens on the channel through single-cycle event pulses: the operation finished, a block finished, the device ended the transfer normally, an error occurred, or a peripheral control line event arrived. Each pulse sets a sticky flag. An error pulse also carries a 5-bit error code, which the block stores.

Software uses a byte-wide register port. It reads the status byte, the error byte and two interrupt vector bytes. It clears sticky flags by writing 1 to their bit positions. Two status bits are not stored. They show the live channel-active condition and the live peripheral line level. The block raises an interrupt request when any completion flag or the error flag is set, unless the channel control interrupt-disable input is high. It presents the error vector while the error flag is set and the normal vector at all other times. It also drives an inhibit that stops the engine from starting a new transfer while the channel still has unacknowledged status or is still active.

Top module: `dma_chan_status`

## Requirements
- R1: The status register is at address 0. Its sticky bits are: bit 7 operation-complete, bit 6 block-complete, bit 5 normal-termination, bit 4 error, and bit 0 peripheral event. Each one becomes 1 in the cycle after its event pulse. It stays 1 until a write to address 0 with 1 in that bit position, or until reset.
- R2: Writing 0 to a status bit has no effect. When a set pulse and a write-1 clear of the same bit fall in the same cycle, the bit stays 1.
- R3: Status bit 3 shows `active_i` and bit 1 shows `pcl_lvl_i` in the same cycle, without latching. Bit 2 reads 0. Writes do not affect these bits.
- R4: `start_block_o` is 1 whenever operation-complete, block-complete, normal-termination or error is 1, or when `active_i` is 1.
- R5: The error register is at address 1. Bits 4..0 hold the error code and bits 7..5 read 0. The code is loaded from `err_code_i` only on an error pulse that finds the error flag at 0 or being cleared in that same cycle. Error pulses that arrive while the flag stays set leave the code unchanged.
- R6: When the error flag is cleared, the error code returns to 00000 in the same cycle.
- R7: `irq_o` is 1 exactly when `int_dis_i` is 0 and at least one of operation-complete, block-complete, normal-termination or error is set. The peripheral event flag does not raise it.
- R8: The normal vector register is at address 2 and the error vector register is at address 3. Both can be written and read back. `vec_o` shows the error vector while the error flag is 1 and the normal vector while it is 0.
- R9: After reset, every sticky flag, the error code and both vectors are 0.
- R10: Addresses 4 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address for read and write |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i (combinational) |
| ev_done_i | input | 1 | Operation-complete pulse |
| ev_blk_i | input | 1 | Block-complete pulse |
| ev_ndt_i | input | 1 | Normal device termination pulse |
| ev_err_i | input | 1 | Error pulse |
| err_code_i | input | 5 | Error code that comes with ev_err_i |
| ev_pcl_i | input | 1 | Peripheral control line event pulse |
| active_i | input | 1 | Live channel-active condition |
| pcl_lvl_i | input | 1 | Live peripheral line level |
| int_dis_i | input | 1 | Interrupt disable from the channel control register |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Selected interrupt vector |
| start_block_o | output | 1 | Inhibit for a new transfer start |

## Verification
Two functions can act in the same cycle: an engine event that sets a flag, and a software write-1 that clears the same flag. The error pulse is the hardest case, because the flag and the code must both come out right. The bench drives these collisions in directed steps, first with the flag already set and then with it clear. It also drives them at random, with event pulses and status writes in the same cycles. A behavioural reference model judges every cycle: it gives set priority and reloads the code only when the flag is free or being freed, and the bench compares the read data, the interrupt, the vector and the start inhibit against it.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int CODE_W = 5;

  localparam int B_DONE = 7;
  localparam int B_BLK  = 6;
  localparam int B_NDT  = 5;
  localparam int B_ERR  = 4;
  localparam int B_ACT  = 3;
  localparam int B_PLV  = 1;
  localparam int B_PEV  = 0;

  localparam logic [DATA_W-1:0] STICKY_MASK =
    DATA_W'((1 << B_DONE) | (1 << B_BLK) | (1 << B_NDT) | (1 << B_ERR) | (1 << B_PEV));

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 3'd0,
    A_ERR  = 3'd1,
    A_NVEC = 3'd2,
    A_EVEC = 3'd3
  } reg_addr_e;
endpackage

// File: rtl/dcs_flags.sv
module dcs_flags #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_sticky
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= set_i[i] | (q & ~clr_i[i]);
      end
      assign q_o[i] = q;

      AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q && !clr_i[i]) |=> q); // R1
      AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> q); // R2
      AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !set_i[i]) |=> !q); // R1
    end else begin : g_none
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/dcs_errcode.sv
module dcs_errcode #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic          flag_i,
  input  logic [CW-1:0] code_i,
  output logic [CW-1:0] code_o
);
  logic          free;
  logic [CW-1:0] code_q;

  // capture only when this pulse is the one that sets the flag
  assign free = !flag_i || clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              code_q <= '0;
    else if (set_i && free)   code_q <= code_i;
    else if (clr_i && !set_i) code_q <= '0;
  end
  assign code_o = code_q;

  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !clr_i) |=> $stable(code_q)); // R5
  AST_CODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !flag_i) |=> (code_q == $past(code_i))); // R5
endmodule

// File: rtl/dcs_vec_regs.sv
module dcs_vec_regs #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_norm_i,
  input  logic         wr_err_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] norm_o,
  output logic [W-1:0] err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      norm_o <= '0;
      err_o  <= '0;
    end else begin
      if (wr_norm_i) norm_o <= wdata_i;
      if (wr_err_i)  err_o  <= wdata_i;
    end
  end

  AST_VEC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_norm_i && !wr_err_i) |=> ($stable(norm_o) && $stable(err_o))); // R8
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              ev_done_i,
  input  logic              ev_blk_i,
  input  logic              ev_ndt_i,
  input  logic              ev_err_i,
  input  logic [CODE_W-1:0] err_code_i,
  input  logic              ev_pcl_i,
  input  logic              active_i,
  input  logic              pcl_lvl_i,
  input  logic              int_dis_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] vec_o,
  output logic              start_block_o
);
  logic [DATA_W-1:0] set_v, clr_v, flags;
  logic [CODE_W-1:0] code;
  logic [DATA_W-1:0] nvec, evec;
  logic              wr_stat, any_done;

  assign wr_stat = wr_en_i && (addr_i == A_STAT);

  always_comb begin
    set_v         = '0;
    set_v[B_DONE] = ev_done_i;
    set_v[B_BLK]  = ev_blk_i;
    set_v[B_NDT]  = ev_ndt_i;
    set_v[B_ERR]  = ev_err_i;
    set_v[B_PEV]  = ev_pcl_i;
  end
  assign clr_v = wr_stat ? wdata_i : '0;

  dcs_flags #(.W(DATA_W), .MASK(STICKY_MASK)) u_flags (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (set_v), .clr_i (clr_v), .q_o(flags)
  );

  dcs_errcode #(.CW(CODE_W)) u_code (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (ev_err_i), .clr_i(clr_v[B_ERR]), .flag_i(flags[B_ERR]),
    .code_i(err_code_i), .code_o(code)
  );

  dcs_vec_regs #(.W(DATA_W)) u_vec (
    .clk_i    (clk_i), .rst_ni(rst_ni),
    .wr_norm_i(wr_en_i && (addr_i == A_NVEC)),
    .wr_err_i (wr_en_i && (addr_i == A_EVEC)),
    .wdata_i  (wdata_i), .norm_o(nvec), .err_o(evec)
  );

  assign any_done      = flags[B_DONE] | flags[B_BLK] | flags[B_NDT] | flags[B_ERR];
  assign start_block_o = any_done | active_i;
  assign irq_o         = any_done & ~int_dis_i;
  assign vec_o         = flags[B_ERR] ? evec : nvec;

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_STAT: begin
        rd_data_o        = flags;
        rd_data_o[B_ACT] = active_i;
        rd_data_o[B_PLV] = pcl_lvl_i;
      end
      A_ERR:  rd_data_o = DATA_W'(code);
      A_NVEC: rd_data_o = nvec;
      A_EVEC: rd_data_o = evec;
      default: rd_data_o = '0;
    endcase
  end

  AST_ERR_START_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_err_i |=> start_block_o); // R4
  AST_IRQ_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_done_i |=> (irq_o || int_dis_i)); // R7
  AST_CODE_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags[B_ERR] |-> (code == '0)); // R6
  AST_VEC_ERR_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_err_i |=> (vec_o == evec)); // R8
endmodule

// File: tb/dma_chan_status_test.sv
module dma_chan_status_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       e_done = 0, e_blk = 0, e_ndt = 0, e_err = 0, e_pcl = 0;
  logic [4:0] ecode = '0;
  logic       act = 0, plv = 0, idis = 0;
  logic [7:0] rd_data, vec;
  logic       irq, sblk;

  int checks = 0;
  int fails  = 0;
  bit done_run = 0;

  // reference model state
  bit       m_done, m_blk, m_ndt, m_err, m_pev;
  bit [4:0] m_code;
  bit [7:0] m_nvec, m_evec;

  always #2 clk = ~clk;

  dma_chan_status uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
    .rd_data_o(rd_data), .ev_done_i(e_done), .ev_blk_i(e_blk), .ev_ndt_i(e_ndt),
    .ev_err_i(e_err), .err_code_i(ecode), .ev_pcl_i(e_pcl), .active_i(act),
    .pcl_lvl_i(plv), .int_dis_i(idis), .irq_o(irq), .vec_o(vec), .start_block_o(sblk)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done = 0; m_blk = 0; m_ndt = 0; m_err = 0; m_pev = 0;
      m_code = 0; m_nvec = 0; m_evec = 0;
    end else begin
      bit [7:0] c;
      c = (wr && addr == 3'd0) ? wdata : 8'h00;
      if (e_err && (!m_err || c[4])) m_code = ecode;
      else if (c[4] && !e_err)       m_code = 0;
      m_done = e_done || (m_done && !c[7]);
      m_blk  = e_blk  || (m_blk  && !c[6]);
      m_ndt  = e_ndt  || (m_ndt  && !c[5]);
      m_err  = e_err  || (m_err  && !c[4]);
      m_pev  = e_pcl  || (m_pev  && !c[0]);
      if (wr && addr == 3'd2) m_nvec = wdata;
      if (wr && addr == 3'd3) m_evec = wdata;
    end
  end

  task automatic chk(string tag, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // compare everything on every falling edge
  always @(negedge clk) begin
    bit [7:0] er;
    bit any;
    any = m_done | m_blk | m_ndt | m_err;
    case (addr)
      3'd0: er = {m_done, m_blk, m_ndt, m_err, act, 1'b0, plv, m_pev};
      3'd1: er = {3'b000, m_code};
      3'd2: er = m_nvec;
      3'd3: er = m_evec;
      default: er = 8'h00;
    endcase
    if (!rst_n) chk("R9 reset", rd_data, er);
    else if (addr == 3'd0) chk("R1 status", rd_data, er);
    else if (addr == 3'd1) chk("R5 errreg", rd_data, er);
    else if (addr <= 3'd3) chk("R8 vecreg", rd_data, er);
    else chk("R10 unused", rd_data, er);
    chk("R7 irq", irq, any && !idis);
    chk("R8 vec", vec, m_err ? m_evec : m_nvec);
    chk("R4 start_block", sblk, any || act);
  end

  task automatic quiet();
    wr = 0; wdata = 0; e_done = 0; e_blk = 0; e_ndt = 0; e_err = 0; e_pcl = 0;
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      quiet();
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d);
    addr = a; wr = 1; wdata = d;
    @(negedge clk); #1; quiet();
  endtask

  initial begin
    #200000;
    if (!done_run) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    for (int a = 0; a < 4; a++) begin addr = 3'(a); @(negedge clk); #1; end
    rst_n = 1;
    tick(1);
    // R8: vectors
    wreg(3'd2, 8'h40); wreg(3'd3, 8'h41);
    addr = 3'd2; tick(1); addr = 3'd3; tick(1);
    // R1 / R7: completion sets flag and irq
    addr = 3'd0; e_done = 1; tick(2);
    // R2: writing zeros has no effect
    wreg(3'd0, 8'h00); tick(1);
    wreg(3'd0, 8'h80); tick(1);
    // R5: first error code kept
    ecode = 5'b00110; e_err = 1; tick(1);
    addr = 3'd1; ecode = 5'b10001; e_err = 1; tick(2);
    // R2: clear and set on the same cycle, new code loads
    addr = 3'd0; wr = 1; wdata = 8'h10; e_err = 1; ecode = 5'b01101; tick(1);
    addr = 3'd1; tick(1);
    // R6: clearing error zeroes code
    wreg(3'd0, 8'h10); addr = 3'd1; tick(1);
    // R7: masked interrupt
    addr = 3'd0; e_blk = 1; e_ndt = 1; tick(1); idis = 1; tick(2); idis = 0; tick(1);
    wreg(3'd0, 8'h60);
    // R3: live bits, peripheral event sticky without irq
    e_pcl = 1; tick(1); act = 1; plv = 1; tick(2);
    wreg(3'd0, 8'h0E); act = 0; tick(1); plv = 0; wreg(3'd0, 8'h01);
    // R10: unused addresses
    for (int a = 4; a < 8; a++) begin wreg(3'(a), 8'hFF); addr = 3'(a); tick(1); end
    // random mix with collisions
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      addr   = 3'($urandom_range(0, 7));
      wr     = ($urandom_range(0, 3) == 0);
      wdata  = 8'($urandom);
      e_done = ($urandom_range(0, 7) == 0);
      e_blk  = ($urandom_range(0, 7) == 0);
      e_ndt  = ($urandom_range(0, 7) == 0);
      e_err  = ($urandom_range(0, 5) == 0);
      ecode  = 5'($urandom);
      e_pcl  = ($urandom_range(0, 7) == 0);
      act    = ($urandom_range(0, 3) == 0);
      plv    = 1'($urandom);
      idis   = ($urandom_range(0, 5) == 0);
    end
    tick(2);
    // R9: asynchronous reset mid-run
    rst_n = 0; addr = 3'd0; tick(2); rst_n = 1; tick(2);
    done_run = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule